// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

The block carries fixed-size messages between a host processor and one co-processor over a single logical channel. A message is 96 bits wide. It has a 64-bit data word and a 32-bit info word, and each word sits in its own register. Each direction has its own 8-entry hardware FIFO. The host's transmit FIFO is the co-processor's receive queue, and the co-processor's transmit FIFO is the host's receive queue.

Each side has a small register bus. The bus uses a request strobe, a write flag, a 2-bit register address, 64-bit write data and combinational read data:

| Address | Register | On write | On read |
|---|---|---|---|
| 0 | data | stages the data word | returns the receive head's data word, no pop |
| 1 | info | commits a message | returns the info word and pops the entry |
| 2 | status | write-1-to-clear for the sticky bits | fill state of both FIFOs and the sticky bits |
| 3 | interrupt enable | sets the enable mask | returns the enable mask |

A sender stages the data word first, then writes the info word to commit the message. A receiver reads the data word first, then reads the info word, which consumes the message. A send is complete once the FIFO accepts it, so there is no completion event. Each side drives four level interrupts that follow the empty and not-empty state of its two FIFOs, each gated by its own enable. The hardware does not look at the message bits. Endpoint numbers or any other field are carried through untouched.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to address 0 only stages the data word and leaves both FIFOs unchanged. The staged word stays until it is rewritten, so repeated commits reuse it.
- R2: A write to address 1 pushes {staged data, wdata[31:0]} into that side's transmit FIFO. The message then appears at the head of the other side's receive FIFO.
- R3: A read of address 0 returns the receive head's data word without popping. A read of address 1 returns the head's info word in bits [31:0], with zero above, and removes the entry.
- R4: Each FIFO holds up to 8 messages, delivered first in, first out. The two directions are independent.
- R5: The status register at address 2 has these fields:
  - [3:0] transmit count, [4] transmit empty, [5] transmit full
  - [11:8] receive count, [12] receive empty, [13] receive full
  - [16] overflow, [17] underflow
  - all other bits are zero
- R6: A commit to a full transmit FIFO is dropped and sets overflow bit 16. The bit stays set until a status write with bit 16 at 1 clears it.
- R7: A pop read of an empty receive FIFO returns zero, leaves the FIFO unchanged and sets underflow bit 17. A status write with bit 17 at 1 clears it. A data-word read of an empty FIFO also returns zero.
- R8: irq_o bit [0] is transmit empty, [1] transmit not empty, [2] receive empty and [3] receive not empty. Each bit is that level ANDed with the matching bit of the enable register at address 3, which reads back.
- R9: All 96 message bits pass through unmodified, including any endpoint bits in either word.
- R10: Reset (rst_ni low) empties both FIFOs and clears the staged words, the enables and the sticky bits, so every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host register access strobe |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 64 | Host write data |
| host_rdata_o | output | 64 | Host read data, valid while a read is requested |
| host_irq_o | output | 4 | Host level interrupts |
| cop_req_i | input | 1 | Co-processor register access strobe |
| cop_we_i | input | 1 | Co-processor write (1) or read (0) |
| cop_addr_i | input | 2 | Co-processor register address |
| cop_wdata_i | input | 64 | Co-processor write data |
| cop_rdata_o | output | 64 | Co-processor read data, valid while a read is requested |
| cop_irq_o | output | 4 | Co-processor level interrupts |

## Verification
The assertions check on every cycle that:
- a commit grows the FIFO fill count by one, a pop shrinks it by one, and a staging write leaves it unchanged;
- a full FIFO refuses a push, and no count ever exceeds the depth;
- a pop of an empty FIFO reads zero;
- the empty and not-empty interrupts of one FIFO are never both high.

Some behaviour only the bench's scenarios can show:
- that the payload bits arrive intact and in order;
- the exact status layout;
- that the sticky bits latch and are cleared by writing 1;
- the interrupt level patterns as the FIFOs fill and drain;
- that a staged word survives between commits.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int DATA_W  = 64;
  localparam int INFO_W  = 32;
  localparam int BUS_W   = 64;
  localparam int ST_CW   = 4;   // status count field width
  localparam int ST_TX   = 0;
  localparam int ST_RX   = 8;
  localparam int ST_OVF  = 16;
  localparam int ST_UDF  = 17;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [INFO_W-1:0] info;
  } msg_t;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_INFO  = 2'd1,
    REG_STAT  = 2'd2,
    REG_IRQEN = 2'd3
  } reg_e;

  typedef enum int {IRQ_TX_EMPTY = 0, IRQ_TX_AVAIL = 1, IRQ_RX_EMPTY = 2, IRQ_RX_AVAIL = 3} irq_e;
endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  msg_t             msg_i,
  input  logic             pop_i,
  output msg_t             head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  msg_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= msg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ipc_mbox_port.sv
module ipc_mbox_port
  import ipc_mbox_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [3:0]       irq_o,
  // own transmit FIFO
  output logic             tx_push_o,
  output msg_t             tx_msg_o,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic             tx_full_i,
  input  logic             tx_empty_i,
  // receive FIFO fed by the peer
  output logic             rx_pop_o,
  input  msg_t             rx_head_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             rx_full_i,
  input  logic             rx_empty_i
);
  logic [DATA_W-1:0] stage_q;
  logic [3:0]        irq_en_q;
  logic              ovf_q, udf_q;
  logic              wr, rd, commit, pop_rd, stat_wr;
  logic [BUS_W-1:0]  status, rd_mux;
  logic [3:0]        level;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign commit  = wr & (addr_i == REG_INFO);
  assign stat_wr = wr & (addr_i == REG_STAT);
  assign pop_rd  = rd & (addr_i == REG_INFO);

  assign tx_push_o = commit & ~tx_full_i;
  assign tx_msg_o  = '{data: stage_q, info: wdata_i[INFO_W-1:0]};
  assign rx_pop_o  = pop_rd & ~rx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      irq_en_q <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      if (wr && addr_i == REG_DATA)  stage_q  <= wdata_i[DATA_W-1:0];
      if (wr && addr_i == REG_IRQEN) irq_en_q <= wdata_i[3:0];
      ovf_q <= (ovf_q & ~(stat_wr & wdata_i[ST_OVF])) | (commit & tx_full_i);
      udf_q <= (udf_q & ~(stat_wr & wdata_i[ST_UDF])) | (pop_rd & rx_empty_i);
    end
  end

  always_comb begin
    status                        = '0;
    status[ST_TX +: ST_CW]        = ST_CW'(tx_cnt_i);
    status[ST_TX + ST_CW]         = tx_empty_i;
    status[ST_TX + ST_CW + 1]     = tx_full_i;
    status[ST_RX +: ST_CW]        = ST_CW'(rx_cnt_i);
    status[ST_RX + ST_CW]         = rx_empty_i;
    status[ST_RX + ST_CW + 1]     = rx_full_i;
    status[ST_OVF]                = ovf_q;
    status[ST_UDF]                = udf_q;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_DATA:  if (!rx_empty_i) rd_mux[DATA_W-1:0] = rx_head_i.data;
      REG_INFO:  if (!rx_empty_i) rd_mux[INFO_W-1:0] = rx_head_i.info;
      REG_STAT:  rd_mux = status;
      default:   rd_mux[3:0] = irq_en_q;
    endcase
  end

  assign rdata_o = rd ? rd_mux : '0;

  assign level[IRQ_TX_EMPTY] = tx_empty_i;
  assign level[IRQ_TX_AVAIL] = ~tx_empty_i;
  assign level[IRQ_RX_EMPTY] = rx_empty_i;
  assign level[IRQ_RX_AVAIL] = ~rx_empty_i;
  assign irq_o = level & irq_en_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_req_i,
  input  logic        host_we_i,
  input  logic [1:0]  host_addr_i,
  input  logic [63:0] host_wdata_i,
  output logic [63:0] host_rdata_o,
  output logic [3:0]  host_irq_o,
  input  logic        cop_req_i,
  input  logic        cop_we_i,
  input  logic [1:0]  cop_addr_i,
  input  logic [63:0] cop_wdata_i,
  output logic [63:0] cop_rdata_o,
  output logic [3:0]  cop_irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SIDES = 2;  // 0: host, 1: co-processor

  logic [SIDES-1:0]            req, we;
  logic [SIDES-1:0][1:0]       addr;
  logic [SIDES-1:0][BUS_W-1:0] wdata, rdata;
  logic [SIDES-1:0][3:0]       irq;
  // FIFO f is written by side f and read by the other side
  msg_t [SIDES-1:0]            push_msg, head;
  logic [SIDES-1:0]            push, pop, full, empty;
  logic [SIDES-1:0][CNT_W-1:0] fifo_cnt;

  assign req   = {cop_req_i, host_req_i};
  assign we    = {cop_we_i, host_we_i};
  assign addr  = {cop_addr_i, host_addr_i};
  assign wdata = {cop_wdata_i, host_wdata_i};
  assign host_rdata_o = rdata[0];
  assign cop_rdata_o  = rdata[1];
  assign host_irq_o   = irq[0];
  assign cop_irq_o    = irq[1];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int PEER = SIDES - 1 - s;

    ipc_mbox_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[s]),
      .msg_i   (push_msg[s]),
      .pop_i   (pop[s]),
      .head_o  (head[s]),
      .cnt_o   (fifo_cnt[s]),
      .full_o  (full[s]),
      .empty_o (empty[s])
    );

    ipc_mbox_port #(.CNT_W(CNT_W)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req[s]),
      .we_i       (we[s]),
      .addr_i     (addr[s]),
      .wdata_i    (wdata[s]),
      .rdata_o    (rdata[s]),
      .irq_o      (irq[s]),
      .tx_push_o  (push[s]),
      .tx_msg_o   (push_msg[s]),
      .tx_cnt_i   (fifo_cnt[s]),
      .tx_full_i  (full[s]),
      .tx_empty_i (empty[s]),
      .rx_pop_o   (pop[PEER]),
      .rx_head_i  (head[PEER]),
      .rx_cnt_i   (fifo_cnt[PEER]),
      .rx_full_i  (full[PEER]),
      .rx_empty_i (empty[PEER])
    );
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            req,
  input logic [1:0]            we,
  input logic [1:0][1:0]       addr,
  input logic [1:0][63:0]      rdata,
  input logic [1:0][3:0]       irq,
  input logic [1:0][CNT_W-1:0] fifo_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  for (genvar s = 0; s < 2; s++) begin : g_chk
    localparam int PEER = 1 - s;
    logic commit, stage, pop_p;
    assign commit = req[s] & we[s] & (addr[s] == 2'd1);
    assign stage  = req[s] & we[s] & (addr[s] == 2'd0);
    assign pop_p  = req[PEER] & ~we[PEER] & (addr[PEER] == 2'd1);

    AST_STAGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage && !pop_p |=> $stable(fifo_cnt[s])); // R1
    AST_COMMIT_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit && fifo_cnt[s] != FULL && !pop_p |=> fifo_cnt[s] == $past(fifo_cnt[s]) + ONE); // R2
    AST_POP_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_p && fifo_cnt[s] != '0 && !commit |=> fifo_cnt[s] == $past(fifo_cnt[s]) - ONE); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_cnt[s] <= FULL); // R4
    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit && fifo_cnt[s] == FULL && !pop_p |=> fifo_cnt[s] == FULL); // R6
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_p && fifo_cnt[s] == '0 |-> rdata[PEER] == '0); // R7
    AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(irq[s][1:0]) && $onehot0(irq[s][3:2])); // R8
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req      (req),
  .we       (we),
  .addr     (addr),
  .rdata    (rdata),
  .irq      (irq),
  .fifo_cnt (fifo_cnt)
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 0, h_we = 0, c_req = 0, c_we = 0;
  logic [1:0]  h_addr = 0, c_addr = 0;
  logic [63:0] h_wd = 0, c_wd = 0, h_rd, c_rd;
  logic [3:0]  h_irq, c_irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ipc_mailbox u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(h_req), .host_we_i(h_we), .host_addr_i(h_addr),
    .host_wdata_i(h_wd), .host_rdata_o(h_rd), .host_irq_o(h_irq),
    .cop_req_i(c_req), .cop_we_i(c_we), .cop_addr_i(c_addr),
    .cop_wdata_i(c_wd), .cop_rdata_o(c_rd), .cop_irq_o(c_irq)
  );

  localparam bit H = 0, C = 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] st(input int tc, input int rc, input bit ov, input bit un);
    logic [63:0] v = '0;
    v[3:0] = 4'(tc); v[4] = (tc == 0); v[5] = (tc == 8);
    v[11:8] = 4'(rc); v[12] = (rc == 0); v[13] = (rc == 8);
    v[16] = ov; v[17] = un;
    return v;
  endfunction

  task automatic acc(input bit side, input bit w, input logic [1:0] a,
                     input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    if (side == H) begin h_req = 1; h_we = w; h_addr = a; h_wd = d; end
    else           begin c_req = 1; c_we = w; c_addr = a; c_wd = d; end
    #1 r = (side == H) ? h_rd : c_rd;
    @(posedge clk); #1;
    h_req = 0; c_req = 0; h_we = 0; c_we = 0;
  endtask

  task automatic wr(input bit side, input logic [1:0] a, input logic [63:0] d);
    logic [63:0] r;
    acc(side, 1'b1, a, d, r);
  endtask

  task automatic rd(input bit side, input logic [1:0] a, input string tag, input logic [63:0] exp);
    logic [63:0] r;
    acc(side, 1'b0, a, 64'h0, r);
    chk(tag, r, exp);
  endtask

  task automatic send(input bit side, input logic [63:0] d, input logic [31:0] i);
    wr(side, 2'd0, d);
    wr(side, 2'd1, {32'h0, i});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    rd(H, 2'd2, "R10 host status after reset", st(0, 0, 0, 0));
    rd(C, 2'd2, "R10 cop status after reset", st(0, 0, 0, 0));
    chk("R10 irq low after reset", {56'h0, c_irq, h_irq}, 64'h0);
  endtask

  task automatic t_roundtrip();
    wr(H, 2'd0, 64'h1122_3344_5566_7788);
    rd(H, 2'd2, "R1 staging write pushes nothing", st(0, 0, 0, 0));
    rd(C, 2'd2, "R1 peer rx still empty", st(0, 0, 0, 0));
    wr(H, 2'd1, 64'hDEAD_0000_0BAD_F00D);
    rd(C, 2'd2, "R2 commit reaches peer rx", st(0, 1, 0, 0));
    rd(H, 2'd2, "R5 host tx count", st(1, 0, 0, 0));
    rd(C, 2'd0, "R3 data peek", 64'h1122_3344_5566_7788);
    rd(C, 2'd2, "R3 peek does not pop", st(0, 1, 0, 0));
    rd(C, 2'd1, "R3 info pop upper bits zero", 64'h0000_0000_0BAD_F00D);
    rd(C, 2'd2, "R3 pop removes entry", st(0, 0, 0, 0));
    wr(H, 2'd1, 64'h0000_0000_0000_0042);
    rd(C, 2'd0, "R1 staged word reused", 64'h1122_3344_5566_7788);
    rd(C, 2'd1, "R2 second info", 64'h42);
  endtask

  task automatic t_order();
    for (int i = 0; i < 8; i++) send(C, 64'hC0DE_0000_0000_0000 + 64'(i), 32'hA5A5_0000 + 32'(i));
    rd(H, 2'd2, "R4 host rx full at 8", st(0, 8, 0, 0));
    rd(C, 2'd2, "R4 cop tx full at 8", st(8, 0, 0, 0));
    rd(H, 2'd2, "R4 other direction independent", st(0, 8, 0, 0));
    for (int i = 0; i < 8; i++) begin
      rd(H, 2'd0, "R4 fifo order data", 64'hC0DE_0000_0000_0000 + 64'(i));
      rd(H, 2'd1, "R4 fifo order info", 64'hA5A5_0000 + 64'(i));
    end
    rd(H, 2'd2, "R4 drained", st(0, 0, 0, 0));
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++) send(H, 64'(i) << 8, 32'h7700 + 32'(i));
    rd(H, 2'd2, "R6 overflow sticky set", st(8, 0, 1, 0));
    rd(C, 2'd2, "R6 ninth message dropped", st(0, 8, 0, 0));
    rd(H, 2'd2, "R6 overflow stays set", st(8, 0, 1, 0));
    wr(H, 2'd2, 64'h0);
    rd(H, 2'd2, "R6 write 0 keeps overflow", st(8, 0, 1, 0));
    wr(H, 2'd2, 64'h1_0000);
    rd(H, 2'd2, "R6 overflow cleared by write 1", st(8, 0, 0, 0));
    for (int i = 0; i < 8; i++) rd(C, 2'd1, "R6 kept entries intact", 64'h7700 + 64'(i));
    rd(C, 2'd2, "R6 nothing after eighth", st(0, 0, 0, 0));
  endtask

  task automatic t_underflow();
    rd(H, 2'd1, "R7 empty pop returns zero", 64'h0);
    rd(H, 2'd0, "R7 empty peek returns zero", 64'h0);
    rd(H, 2'd2, "R7 underflow sticky set", st(0, 0, 0, 1));
    wr(H, 2'd2, 64'h2_0000);
    rd(H, 2'd2, "R7 underflow cleared", st(0, 0, 0, 0));
  endtask

  task automatic t_irq();
    wr(H, 2'd3, 64'hF);
    rd(H, 2'd3, "R8 enable readback", 64'hF);
    chk("R8 both empty", 64'(h_irq), 64'b0101);
    send(C, 64'h5, 32'h5);
    chk("R8 rx not empty", 64'(h_irq), 64'b1001);
    send(H, 64'h6, 32'h6);
    chk("R8 tx not empty", 64'(h_irq), 64'b1010);
    chk("R8 disabled side silent", 64'(c_irq), 64'h0);
    wr(C, 2'd3, 64'h8);
    chk("R8 cop rx avail only", 64'(c_irq), 64'b1000);
    wr(H, 2'd3, 64'h2);
    chk("R8 single enable", 64'(h_irq), 64'b0010);
    rd(C, 2'd1, "R8 drain cop", 64'h6);
    chk("R8 level follows drain", 64'(h_irq), 64'h0);
    rd(H, 2'd1, "R8 drain host", 64'h5);
    wr(H, 2'd3, 64'h0);
    wr(C, 2'd3, 64'h0);
  endtask

  task automatic t_endpoint();
    send(H, 64'hFF00_0000_0000_00FF, 32'hFFFF_FFFF);
    send(H, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_00FE);
    rd(C, 2'd0, "R9 data bits intact", 64'hFF00_0000_0000_00FF);
    rd(C, 2'd1, "R9 info bits intact", 64'hFFFF_FFFF);
    rd(C, 2'd0, "R9 all-ones data", 64'hFFFF_FFFF_FFFF_FFFF);
    rd(C, 2'd1, "R9 endpoint byte", 64'hFE);
  endtask

  task automatic t_reset_mid();
    send(H, 64'hABCD, 32'h1);
    send(C, 64'hEF01, 32'h2);
    wr(H, 2'd3, 64'hF);
    wr(H, 2'd1, 64'h0);  // fills a FIFO slot
    do_reset();
    rd(H, 2'd2, "R10 host fifos emptied", st(0, 0, 0, 0));
    rd(C, 2'd2, "R10 cop fifos emptied", st(0, 0, 0, 0));
    rd(H, 2'd3, "R10 enables cleared", 64'h0);
    wr(H, 2'd1, 64'h9);
    rd(C, 2'd0, "R10 staged word cleared", 64'h0);
    rd(C, 2'd1, "R10 post-reset message", 64'h9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_roundtrip();
    t_order();
    t_overflow();
    t_underflow();
    t_irq();
    t_endpoint();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule